// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger Block

This block sits between the serial shifters of a 16550-style UART and its host-side register file. It holds the FIFO control byte and the two byte queues that the byte controls: a receive queue that the receive shifter fills and the host drains, and a transmit queue that the host fills and the transmit shifter drains. A single 8-bit write port with a strobe programs the control byte. Each queue has a push and pop interface with show-ahead read data.

With FIFO mode on, each queue holds up to sixteen bytes. A 2-bit code in the control byte selects the receive fill level at which the data-ready interrupt is raised. Two self-clearing bits empty either queue on demand and leave the shifters alone. A stored flag reports the DMA mode to the surrounding logic. With FIFO mode off, each direction shrinks to a single holding byte. In that mode the interrupt follows the presence of that one byte.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After synchronous reset, FIFO mode is off, the trigger code is 00, `dma_mode` is 0, both counts are 0, both empty flags are 1, both full flags are 0, `rx_overrun` is 0 and `rx_data_irq` is 0.
- R2: In FIFO mode each queue stores up to 16 bytes and returns them in push order. The count runs from 0 to 16, full is set at 16 and empty at 0. A push to a full transmit queue is dropped.
- R3: A receive push while the receive queue is full discards the byte and sets `rx_overrun`. The flag stays set until a receive clear is written or a control write has bit 0 at 0.
- R4: Bits 7:6 of a control write select the receive trigger level: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. In FIFO mode `rx_data_irq` is high exactly while `rx_irq_en` is 1 and `rx_count` is at or above that level.
- R5: While `rx_irq_en` is 0, `rx_data_irq` is 0.
- R6: A control write with bits 0 and 2 both at 1 empties the transmit queue by the next cycle and leaves the receive queue intact. With bit 2 at 0, a write leaves the transmit contents untouched.
- R7: A control write with bits 0 and 1 both at 1 empties the receive queue and clears `rx_overrun` by the next cycle, and leaves the transmit queue intact.
- R8: A control write with bit 0 at 0 enters non-FIFO mode and empties both queues. The trigger code and `dma_mode` keep their previous values, and bits 1 and 2 are ignored.
- R9: A control write with bit 0 at 1 stores bits 7:6 as the trigger code and bit 3 as `dma_mode`; bits 5:4 have no effect. A write that turns FIFO mode on from off also empties both queues.
- R10: In non-FIFO mode each direction holds one byte: full is set at count 1, and `rx_data_irq` equals `rx_irq_en` while that byte is present, whatever the trigger code.
- R11: When a receive clear and a receive push fall in the same cycle, the receive queue ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| rx_push | input | 1 | Receive shifter pushes a byte |
| rx_push_data | input | 8 | Byte pushed into the receive queue |
| rx_pop | input | 1 | Host pops the receive head |
| rx_pop_data | output | 8 | Receive queue head (show-ahead) |
| rx_count | output | 5 | Bytes held in the receive queue |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_irq_en | input | 1 | Enable for the data-ready interrupt |
| rx_data_irq | output | 1 | Receive data-ready interrupt |
| tx_push | input | 1 | Host pushes a byte to transmit |
| tx_push_data | input | 8 | Byte pushed into the transmit queue |
| tx_pop | input | 1 | Transmit shifter pops the head |
| tx_pop_data | output | 8 | Transmit queue head (show-ahead) |
| tx_count | output | 5 | Bytes held in the transmit queue |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| dma_mode | output | 1 | Stored DMA mode flag |

## Verification
Several rules are checked on every cycle: the count bounds and the one-byte limit in non-FIFO mode, the interrupt gating by the enable, the interrupt at an empty queue and at fourteen bytes, overrun on a push into a full queue, the effect of each clear bit one cycle later, and a mode-leave write that holds the DMA flag. Only the bench scenarios can show that bytes come out in push order, that each of the four trigger codes switches at its own count, and that a zero in a clear bit leaves data untouched. The same holds for the fields a write with bit 0 low leaves unprogrammed, which show up only after a later mode change.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int DEF_DATA_W     = 8;
    localparam int DEF_FIFO_DEPTH = 16;

    // control byte field positions (decoded by the register stage)
    localparam int BIT_FIFO_ON = 0;
    localparam int BIT_RX_CLR  = 1;
    localparam int BIT_TX_CLR  = 2;
    localparam int BIT_DMA     = 3;
    localparam int TRIG_LSB    = 6;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_code_e;

    typedef struct packed {
        logic       fifo_on;
        trig_code_e trig;
        logic       dma;
    } fifo_ctrl_t;

    typedef struct packed {
        logic rx;
        logic tx;
    } flush_req_t;

    function automatic int trig_level(trig_code_e code);
        case (code)
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             push_drop
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] next_ptr(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap       = single ? CNT_W'(1) : CNT_W'(DEPTH);
    assign full      = (cnt >= cap);
    assign empty     = (cnt == '0);
    assign push_ok   = push && !full;
    assign pop_ok    = pop && !empty;
    assign push_drop = push && full && !flush;
    assign pop_data  = mem[rd_ptr];
    assign count     = cnt;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/fifo_ctrl_reg.sv
module fifo_ctrl_reg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output fifo_ctrl_t ctrl,
    output flush_req_t flush
);

    logic wr_on;
    logic mode_flush;
    logic unused_rsvd;

    assign wr_on       = wdata[BIT_FIFO_ON];
    assign unused_rsvd = ^wdata[5:4];

    // leaving FIFO mode, or entering it from off, empties both queues
    assign mode_flush = we && (!wr_on || !ctrl.fifo_on);

    // clear bits act only in the write cycle and are never stored
    assign flush.rx = mode_flush || (we && wr_on && wdata[BIT_RX_CLR]);
    assign flush.tx = mode_flush || (we && wr_on && wdata[BIT_TX_CLR]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.fifo_on <= 1'b0;
            ctrl.trig    <= TRIG_1;
            ctrl.dma     <= 1'b0;
        end else if (we) begin
            ctrl.fifo_on <= wr_on;
            if (wr_on) begin
                ctrl.trig <= trig_code_e'(wdata[TRIG_LSB +: 2]);
                ctrl.dma  <= wdata[BIT_DMA];
            end
        end
    end

endmodule

// File: rtl/rx_trigger.sv
module rx_trigger
    import uart_fifo_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             fifo_on,
    input  trig_code_e       trig,
    input  logic [CNT_W-1:0] count,
    input  logic             irq_en,
    output logic             irq
);

    logic [CNT_W-1:0] level;

    assign level = fifo_on ? CNT_W'(trig_level(trig)) : CNT_W'(1);
    assign irq   = irq_en && (count >= level);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int FIFO_DEPTH = DEF_FIFO_DEPTH,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_overrun,
    input  logic              rx_irq_en,
    output logic              rx_data_irq,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              dma_mode
);

    fifo_ctrl_t ctrl;
    flush_req_t flush;
    logic       fifo_on;
    logic       rx_drop;
    logic       tx_drop;
    logic       unused_tx_drop;

    assign fifo_on        = ctrl.fifo_on;
    assign dma_mode       = ctrl.dma;
    assign unused_tx_drop = tx_drop;

    fifo_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .flush (flush)
    );

    byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush.rx),
        .single    (!fifo_on),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty),
        .push_drop (rx_drop)
    );

    byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush.tx),
        .single    (!fifo_on),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty),
        .push_drop (tx_drop)
    );

    rx_trigger #(.CNT_W(CNT_W)) u_trig (
        .fifo_on (fifo_on),
        .trig    (ctrl.trig),
        .count   (rx_count),
        .irq_en  (rx_irq_en),
        .irq     (rx_data_irq)
    );

    always_ff @(posedge clk) begin
        if (rst || flush.rx) begin
            rx_overrun <= 1'b0;
        end else if (rx_drop) begin
            rx_overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic             rx_push,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_full,
    input logic             rx_empty,
    input logic             rx_overrun,
    input logic             rx_irq_en,
    input logic             rx_data_irq,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_empty,
    input logic             dma_mode,
    input logic             fifo_on
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (rx_count == '0 && tx_count == '0 && !dma_mode && !rx_overrun && !fifo_on));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_count <= CNT_W'(FIFO_DEPTH)) && (tx_count <= CNT_W'(FIFO_DEPTH)));

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full && !cfg_we) |=> rx_overrun);

    p_irq_empty_r4: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> !rx_data_irq);

    p_irq_top_level_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_irq_en && rx_count >= CNT_W'(14)) |-> rx_data_irq);

    p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !rx_irq_en |-> !rx_data_irq);

    p_tx_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[0] && cfg_wdata[2]) |=> (tx_count == '0 && tx_empty));

    p_rx_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[0] && cfg_wdata[1]) |=> (rx_count == '0 && !rx_overrun));

    p_leave_mode_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_wdata[0]) |=> (rx_count == '0 && tx_count == '0 && $stable(dma_mode)));

    p_single_byte_r10: assert property (@(posedge clk) disable iff (rst)
        !fifo_on |-> (rx_count <= CNT_W'(1) && tx_count <= CNT_W'(1)));

    p_clear_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[0] && cfg_wdata[1] && rx_push) |=> rx_empty);

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .rx_push     (rx_push),
    .rx_count    (rx_count),
    .rx_full     (rx_full),
    .rx_empty    (rx_empty),
    .rx_overrun  (rx_overrun),
    .rx_irq_en   (rx_irq_en),
    .rx_data_irq (rx_data_irq),
    .tx_count    (tx_count),
    .tx_empty    (tx_empty),
    .dma_mode    (dma_mode),
    .fifo_on     (fifo_on)
);

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic       rx_push;
    logic [7:0] rx_push_data;
    logic       rx_pop;
    logic [7:0] rx_pop_data;
    logic [4:0] rx_count;
    logic       rx_full;
    logic       rx_empty;
    logic       rx_overrun;
    logic       rx_irq_en;
    logic       rx_data_irq;
    logic       tx_push;
    logic [7:0] tx_push_data;
    logic       tx_pop;
    logic [7:0] tx_pop_data;
    logic [4:0] tx_count;
    logic       tx_full;
    logic       tx_empty;
    logic       dma_mode;

    int checks = 0;
    int errors = 0;

    // scoreboard model
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit m_on  = 0;
    bit m_dma = 0;
    bit m_ovr = 0;
    int m_lvl = 1;

    always #2.5 clk = ~clk;

    uart_fifo_ctrl dut (.*);

    function automatic int m_cap();
        return m_on ? 16 : 1;
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        int lvl;
        lvl = m_on ? m_lvl : 1;
        check_eq(req, "rx_count", int'(rx_count), rxq.size());
        check_eq(req, "tx_count", int'(tx_count), txq.size());
        check_eq(req, "rx_full", int'(rx_full), int'(rxq.size() >= m_cap()));
        check_eq(req, "rx_empty", int'(rx_empty), int'(rxq.size() == 0));
        check_eq(req, "tx_full", int'(tx_full), int'(txq.size() >= m_cap()));
        check_eq(req, "rx_overrun", int'(rx_overrun), int'(m_ovr));
        check_eq(req, "dma_mode", int'(dma_mode), int'(m_dma));
        check_eq(req, "rx_data_irq", int'(rx_data_irq),
                 int'(rx_irq_en && rxq.size() >= lvl));
    endtask

    function automatic void model_write(logic [7:0] d, bit with_rx_push);
        if (d[0]) begin
            if (!m_on) begin
                rxq.delete(); txq.delete(); m_ovr = 0;
            end
            m_on = 1;
            m_dma = d[3];
            case (d[7:6])
                2'b00: m_lvl = 1;
                2'b01: m_lvl = 4;
                2'b10: m_lvl = 8;
                default: m_lvl = 14;
            endcase
            if (d[1]) begin rxq.delete(); m_ovr = 0; end
            if (d[2]) txq.delete();
        end else begin
            m_on = 0;
            rxq.delete(); txq.delete(); m_ovr = 0;
        end
        if (with_rx_push) begin end
    endfunction

    task automatic cfg_write(logic [7:0] d);
        cfg_we = 1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
        model_write(d, 0);
    endtask

    task automatic push_rx(logic [7:0] d);
        rx_push = 1; rx_push_data = d;
        @(posedge clk); #1;
        rx_push = 0;
        if (rxq.size() < m_cap()) rxq.push_back(d);
        else m_ovr = 1;
    endtask

    task automatic push_tx(logic [7:0] d);
        tx_push = 1; tx_push_data = d;
        @(posedge clk); #1;
        tx_push = 0;
        if (txq.size() < m_cap()) txq.push_back(d);
    endtask

    task automatic pop_rx(string req);
        if (rxq.size() > 0) begin
            check_eq(req, "rx_pop_data", int'(rx_pop_data), int'(rxq.pop_front()));
        end
        rx_pop = 1;
        @(posedge clk); #1;
        rx_pop = 0;
    endtask

    task automatic pop_tx(string req);
        if (txq.size() > 0) begin
            check_eq(req, "tx_pop_data", int'(tx_pop_data), int'(txq.pop_front()));
        end
        tx_pop = 1;
        @(posedge clk); #1;
        tx_pop = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_wdata = 0;
        rx_push = 0; rx_push_data = 0; rx_pop = 0;
        tx_push = 0; tx_push_data = 0; tx_pop = 0;
        rx_irq_en = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        check_state("R1");
        check_eq("R1", "tx_empty", int'(tx_empty), 1);

        // R10 non-FIFO single holding byte, irq on one byte
        push_rx(8'hA5);
        check_state("R10");
        push_rx(8'h11);                 // dropped, overrun (R3)
        check_state("R3");
        pop_rx("R10");
        check_state("R10");
        push_tx(8'h3C);
        push_tx(8'h3D);
        check_state("R10");

        // R8 write with bit 0 low clears overrun and queues
        cfg_write(8'h00);
        check_state("R8");

        // R9 enter FIFO mode: trigger 14, dma on
        cfg_write(8'hC9);
        check_state("R9");
        for (int i = 0; i < 13; i++) push_rx(8'h10 + 8'(i));
        check_state("R4");              // 13 bytes, below 14
        push_rx(8'h1D);
        check_state("R4");              // reaches 14
        pop_rx("R2");
        check_state("R4");              // back to 13
        for (int i = 0; i < 3; i++) push_rx(8'h40 + 8'(i));
        check_state("R2");              // 16, full
        push_rx(8'hEE);
        check_state("R3");              // dropped, overrun set
        for (int i = 0; i < 16; i++) pop_rx("R2");
        check_state("R2");

        // R9 trigger 4, dma off, reserved bits set
        cfg_write(8'h71);
        check_state("R9");
        for (int i = 0; i < 3; i++) push_rx(8'h50 + 8'(i));
        check_state("R4");
        push_rx(8'h53);
        check_state("R4");
        rx_irq_en = 0; #1;
        check_state("R5");
        rx_irq_en = 1; #1;

        // R7 receive clear leaves tx alone; overrun still sticky before it
        push_tx(8'h61);
        push_tx(8'h62);
        check_state("R3");
        cfg_write(8'h43);
        check_state("R7");

        // R6 zero in clear bit keeps tx data, then clear it
        cfg_write(8'h41);
        check_state("R6");
        push_tx(8'h63);
        pop_tx("R2");
        pop_tx("R2");
        pop_tx("R2");
        check_state("R2");
        push_tx(8'h71);
        push_tx(8'h72);
        push_rx(8'h73);
        cfg_write(8'h45);
        check_state("R6");

        // R11 clear and push in the same cycle
        push_rx(8'h81);
        cfg_we = 1; cfg_wdata = 8'h43;
        rx_push = 1; rx_push_data = 8'h82;
        @(posedge clk); #1;
        cfg_we = 0; rx_push = 0;
        model_write(8'h43, 1);
        check_state("R11");

        // R8 leaving mode keeps dma and trigger; R10 irq ignores trigger
        cfg_write(8'h49);
        push_rx(8'h91);
        push_rx(8'h92);
        cfg_write(8'h86);
        check_state("R8");
        push_rx(8'h93);
        check_state("R10");
        check_eq("R10", "rx_data_irq", int'(rx_data_irq), 1);

        // R9 entering FIFO mode from off empties queues
        push_tx(8'h94);
        cfg_write(8'h01);
        check_state("R9");

        finish_run();
    end

endmodule